// File: doc/BRIEF.md
# Receiver Polling Sequencer

This block duty-cycles a wake-on-signal radio receiver. While nothing is being received it loops through three phases: a sleep phase in which every signal-processing enable is off and the active indicator is low, a start-up phase in which the processing circuits are powered and allowed to settle, and a bit-check phase in which an external checking unit judges the incoming stream. A failed verdict sends it back to sleep. A passing verdict moves it into the receive phase, where it stays until the host releases it.

The sleep length is a 5-bit configuration word scaled by a basic time unit. The word is taken at the moment sleep is entered, so a later change applies from the next sleep onwards. The host has two independent ways back to polling from the receive phase: hold the serial data line low for a minimum number of clock cycles, or drive the polling/on pin low. Both host pins are ignored in every other phase.

Top module: `rxpoll_top`

## Requirements
- R1: During and after reset the phase is sleep (code 0), the active indicator is low and all enables are off. The first sleep lasts (DEFAULT_SLEEP+1)*SLEEP_UNIT cycles after reset is released.
- R2: The phase code on `phase_o` is 0 for sleep, 1 for start-up, 2 for bit-check and 3 for receive. In sleep, `active_o` is 0 and every bit of `proc_en_o` is 0. In the other three phases, `active_o` is 1 and every bit of `proc_en_o` is 1.
- R3: Sleep lasts (w+1)*SLEEP_UNIT cycles, where w is the value of `cfg_sleep` at the clock edge that enters sleep. Changing `cfg_sleep` during sleep has no effect on the sleep already in progress.
- R4: Start-up lasts STARTUP_CYCLES cycles and is then followed by bit-check. `chk_en_o` is high only in bit-check.
- R5: Bit-check waits for a verdict for as long as it takes. A pass pulse without a fail pulse moves it to receive on the next cycle. Verdict inputs are ignored in all other phases.
- R6: A fail pulse in bit-check returns the sequencer to sleep on the next cycle. Fail wins when pass and fail arrive together.
- R7: In receive, `pol_on_n` low at a clock edge returns the sequencer to sleep on that edge.
- R8: In receive, `data_in` low at DATA_LOW_MIN consecutive clock edges returns the sequencer to sleep on the last of those edges. A shorter low run has no effect. `recv_o` is high exactly in receive.
- R9: `data_in` and `pol_on_n` have no effect in sleep, start-up or bit-check. Receive can only be entered from bit-check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sleep | input | 5 | Sleep length word, sampled when sleep is entered |
| chk_pass | input | 1 | Pass verdict from the bit-check unit |
| chk_fail | input | 1 | Fail verdict from the bit-check unit |
| data_in | input | 1 | Level of the serial data line as driven by the host |
| pol_on_n | input | 1 | Polling/on pin, low requests return to polling |
| active_o | output | 1 | Active indicator, low only in sleep |
| proc_en_o | output | NUM_EN | Enables for the signal-processing circuits |
| chk_en_o | output | 1 | Enable for the external bit-check unit |
| recv_o | output | 1 | High while in receive |
| phase_o | output | 2 | Current phase code |

## Verification
The assertions assume that the verdict, host and configuration inputs are stable across each clock edge. They also assume that a verdict is a level sampled at an edge, with no relation to edges that came before. They do not assume that the verdicts are exclusive or that they occur only in bit-check. The stimulus therefore changes every input only on the falling clock edge. It raises pass and fail at random in every phase, sometimes both together. It pulls the data line low in runs both shorter and longer than the release threshold, and pulls the polling pin low outside receive as well as inside it, so that the ignore rules are exercised.

// File: rtl/rxpoll_pkg.sv
// Shared types for the receiver polling sequencer.
package rxpoll_pkg;
    // Phase codes; the numeric values are visible on phase_o.
    typedef enum logic [1:0] {
        PH_SLEEP = 2'd0,
        PH_START = 2'd1,
        PH_CHECK = 2'd2,
        PH_RECV  = 2'd3
    } phase_t;
endpackage

// File: rtl/rxpoll_timer.sv
// Phase length down-counter.
// Loaded with (length-1) on the edge that enters a timed phase, it counts to
// zero and holds there. expired is high while the count is zero.
// Assumes load is only raised on a phase transition.
module rxpoll_timer #(
    parameter int CW      = 9,
    parameter int RST_VAL = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Reload on a phase change, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= CW'(RST_VAL);
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R3 / R4: a load is taken exactly.
    a_r3_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
    // R3 / R4: without a load the count moves down by one or rests at zero.
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/rxpoll_low_detect.sv
// Host release detector for the data line.
// Counts consecutive edges with the data line low while armed. hit is high on
// the edge that completes DATA_LOW_MIN low samples. Disarming clears the run.
module rxpoll_low_detect #(
    parameter int DATA_LOW_MIN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic data_in,
    output logic hit
);
    localparam int LW = $clog2(DATA_LOW_MIN + 1);

    logic [LW-1:0] run;

    // Track the length of the current low run while armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || data_in) run <= '0;
        else if (run != LW'(DATA_LOW_MIN)) run <= run + 1'b1;
    end

    assign hit = arm && !data_in && (run == LW'(DATA_LOW_MIN - 1));

    generate
        if (DATA_LOW_MIN > 1) begin : g_run_chk
            // R8: a hit always follows a low sample on the previous edge.
            a_r8_run_before_hit: assert property (@(posedge clk) disable iff (!rst_n)
                hit |-> $past(!data_in && arm));
        end
    endgenerate
endmodule

// File: rtl/rxpoll_fsm.sv
// Phase sequencer: sleep -> start-up -> bit-check -> (receive | sleep).
// Raises timer load with the next phase length on every entry to a timed phase.
// Assumes the verdict and host inputs are stable around the clock edge.
module rxpoll_fsm
    import rxpoll_pkg::*;
#(
    parameter int CW             = 9,
    parameter int SLEEP_UNIT     = 8,
    parameter int STARTUP_CYCLES = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          expired,
    input  logic          chk_pass,
    input  logic          chk_fail,
    input  logic          pol_low,
    input  logic          data_hit,
    input  logic [4:0]    cfg_sleep,
    output phase_t        phase,
    output logic          load,
    output logic [CW-1:0] load_val
);
    phase_t        nxt;
    logic [CW-1:0] sleep_len;

    // Sleep length minus one, from the word present at the entry edge.
    always_comb begin
        sleep_len = ({{(CW-5){1'b0}}, cfg_sleep} + CW'(1)) * CW'(SLEEP_UNIT) - CW'(1);
    end

    // Next-phase selection with fail priority over pass.
    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_SLEEP: if (expired) nxt = PH_START;
            PH_START: if (expired) nxt = PH_CHECK;
            PH_CHECK: begin
                if (chk_fail)      nxt = PH_SLEEP;
                else if (chk_pass) nxt = PH_RECV;
            end
            PH_RECV:  if (pol_low || data_hit) nxt = PH_SLEEP;
            default:  nxt = PH_SLEEP;
        endcase
    end

    // Timer reload on entry to a timed phase.
    always_comb begin
        load     = (nxt != phase) && (nxt == PH_SLEEP || nxt == PH_START);
        load_val = (nxt == PH_START) ? CW'(STARTUP_CYCLES - 1) : sleep_len;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_SLEEP;
        else        phase <= nxt;
    end

    // R5: bit-check waits without a verdict.
    a_r5_wait_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CHECK && !chk_pass && !chk_fail) |=> phase == PH_CHECK);
    // R5: pass alone enters receive.
    a_r5_pass_recv: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CHECK && chk_pass && !chk_fail) |=> phase == PH_RECV);
    // R6: fail returns to sleep, even together with pass.
    a_r6_fail_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CHECK && chk_fail) |=> phase == PH_SLEEP);
    // R7: polling pin low in receive returns to sleep.
    a_r7_pin_release: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RECV && pol_low) |=> phase == PH_SLEEP);
    // R4: start-up holds until its timer runs out.
    a_r4_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_START && !expired) |=> phase == PH_START);
    // R9: sleep only leads to sleep or start-up.
    a_r9_sleep_exit: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_SLEEP |=> (phase == PH_SLEEP || phase == PH_START));
    // R9: receive is entered only from bit-check.
    a_r9_recv_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_RECV) ##1 (phase == PH_RECV) |-> $past(phase) == PH_CHECK);
endmodule

// File: rtl/rxpoll_top.sv
// Receiver polling sequencer top.
// Ties the phase machine to its phase timer and the data-line release detector,
// and decodes the phase into the enable and indicator outputs.
// Assumes all inputs are synchronous to clk.
module rxpoll_top
    import rxpoll_pkg::*;
#(
    parameter int SLEEP_UNIT     = 8,
    parameter int STARTUP_CYCLES = 6,
    parameter int DATA_LOW_MIN   = 5,
    parameter int DEFAULT_SLEEP  = 3,
    parameter int NUM_EN         = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        cfg_sleep,
    input  logic              chk_pass,
    input  logic              chk_fail,
    input  logic              data_in,
    input  logic              pol_on_n,
    output logic              active_o,
    output logic [NUM_EN-1:0] proc_en_o,
    output logic              chk_en_o,
    output logic              recv_o,
    output logic [1:0]        phase_o
);
    localparam int MAXLEN = (32 * SLEEP_UNIT > STARTUP_CYCLES) ? 32 * SLEEP_UNIT : STARTUP_CYCLES;
    localparam int CW     = $clog2(MAXLEN) + 1;
    localparam int RSTV   = (DEFAULT_SLEEP + 1) * SLEEP_UNIT - 1;

    phase_t        phase;
    logic          expired, load, data_hit;
    logic [CW-1:0] load_val;

    rxpoll_timer #(.CW(CW), .RST_VAL(RSTV)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
    );

    rxpoll_low_detect #(.DATA_LOW_MIN(DATA_LOW_MIN)) u_low (
        .clk(clk), .rst_n(rst_n), .arm(phase == PH_RECV), .data_in(data_in), .hit(data_hit)
    );

    rxpoll_fsm #(.CW(CW), .SLEEP_UNIT(SLEEP_UNIT), .STARTUP_CYCLES(STARTUP_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .expired(expired), .chk_pass(chk_pass),
        .chk_fail(chk_fail), .pol_low(!pol_on_n), .data_hit(data_hit),
        .cfg_sleep(cfg_sleep), .phase(phase), .load(load), .load_val(load_val)
    );

    // Phase decode for indicator and single-purpose enables.
    always_comb begin
        active_o = (phase != PH_SLEEP);
        chk_en_o = (phase == PH_CHECK);
        recv_o   = (phase == PH_RECV);
        phase_o  = phase;
    end

    // One enable per processing circuit, all driven from the active phase.
    generate
        for (genvar g = 0; g < NUM_EN; g++) begin : g_en
            assign proc_en_o[g] = active_o;
        end
    endgenerate

    // R2: enables never disagree with the indicator across a phase step.
    a_r2_en_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> ($past(phase) == PH_SLEEP && proc_en_o == {NUM_EN{1'b1}}));
    // R1 / R2: leaving activity always lands in sleep with enables off.
    a_r1_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> (proc_en_o == '0 && !chk_en_o && !recv_o));
endmodule

// File: tb/test_rxpoll_top.sv
`timescale 1ns/1ps
module test_rxpoll_top;
    localparam int U   = 8;
    localparam int SU  = 6;
    localparam int DLM = 5;
    localparam int DEF = 3;
    localparam int NE  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    cfg_sleep = 5'd5;
    logic          chk_pass = 1'b0, chk_fail = 1'b0, data_in = 1'b1, pol_on_n = 1'b1;
    logic          active_o, chk_en_o, recv_o;
    logic [NE-1:0] proc_en_o;
    logic [1:0]    phase_o;

    int tests = 0, fails = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    // Reference model state
    int m_ph = 0, m_rem = (DEF + 1) * U, m_low = 0;

    always #2 clk = ~clk;

    rxpoll_top #(.SLEEP_UNIT(U), .STARTUP_CYCLES(SU), .DATA_LOW_MIN(DLM),
                 .DEFAULT_SLEEP(DEF), .NUM_EN(NE)) i_rxpoll_top (
        .clk(clk), .rst_n(rst_n), .cfg_sleep(cfg_sleep), .chk_pass(chk_pass),
        .chk_fail(chk_fail), .data_in(data_in), .pol_on_n(pol_on_n),
        .active_o(active_o), .proc_en_o(proc_en_o), .chk_en_o(chk_en_o),
        .recv_o(recv_o), .phase_o(phase_o)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input int ph);
        case (ph)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R7";
        endcase
    endfunction

    // Reference model, from the requirements, stepped on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_rem = (DEF + 1) * U; m_low = 0;
        end else begin
            case (m_ph)
                0: begin m_rem--; if (m_rem == 0) begin m_ph = 1; m_rem = SU; end end
                1: begin m_rem--; if (m_rem == 0) m_ph = 2; end
                2: if (chk_fail) begin m_ph = 0; m_rem = (cfg_sleep + 1) * U; end
                   else if (chk_pass) begin m_ph = 3; m_low = 0; end
                default: begin
                    m_low = data_in ? 0 : m_low + 1;
                    if (!pol_on_n || m_low == DLM) begin
                        m_ph = 0; m_rem = (cfg_sleep + 1) * U; m_low = 0;
                    end
                end
            endcase
        end
    end

    // Compare all outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            check(tag_of(m_ph), phase_o, m_ph);
            check("R2", active_o, (m_ph != 0));
            check("R2", proc_en_o, (m_ph != 0) ? (1 << NE) - 1 : 0);
            check("R4", chk_en_o, (m_ph == 2));
            check("R8", recv_o, (m_ph == 3));
        end
    end

    task automatic wait_phase(input int p);
        for (int i = 0; i < 2000; i++) begin
            if (phase_o == p) return;
            @(negedge clk);
        end
        check("R4", phase_o, p);
    endtask

    task automatic enter_recv();
        wait_phase(2);
        chk_pass = 1'b1; @(negedge clk); chk_pass = 1'b0;
        check("R5", phase_o, 3);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int dip;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1", phase_o, 0);
        check("R1", active_o, 0);
        check("R1", proc_en_o, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R1: first sleep length after reset comes from the default word.
        for (int i = 1; i <= (DEF + 1) * U; i++) begin
            @(negedge clk);
            if (i == (DEF + 1) * U - 1) check("R1", active_o, 0);
            if (i == (DEF + 1) * U)     check("R1", active_o, 1);
        end
        // R4: start-up length.
        n = 0;
        while (phase_o == 1 && n < 100) begin @(negedge clk); n++; end
        check("R4", n, SU);
        // R6: pass and fail together -> sleep, with a short word.
        cfg_sleep = 5'd2;
        chk_pass = 1'b1; chk_fail = 1'b1;
        @(negedge clk);
        chk_pass = 1'b0; chk_fail = 1'b0;
        check("R6", phase_o, 0);
        // R3: change the word mid-sleep; the length stays (2+1)*U.
        cfg_sleep = 5'd31;
        // R9: host pins during sleep do nothing.
        pol_on_n = 1'b0; data_in = 1'b0;
        n = 0;
        while (phase_o == 0 && n < 1000) begin @(negedge clk); n++; end
        check("R3", n, 3 * U);
        check("R9", phase_o, 1);
        // R9: host pins during start-up and bit-check do nothing.
        wait_phase(2);
        repeat (3) @(negedge clk);
        check("R9", phase_o, 2);
        pol_on_n = 1'b1; data_in = 1'b1;
        cfg_sleep = 5'd1;
        chk_pass = 1'b1; @(negedge clk); chk_pass = 1'b0;
        check("R5", phase_o, 3);
        // R8: a short low run is ignored.
        data_in = 1'b0; repeat (DLM - 1) @(negedge clk); data_in = 1'b1;
        @(negedge clk);
        check("R8", phase_o, 3);
        // R5: verdicts in receive are ignored.
        chk_fail = 1'b1; @(negedge clk); chk_fail = 1'b0;
        check("R5", phase_o, 3);
        // R7: polling pin low for one edge.
        pol_on_n = 1'b0; @(negedge clk); pol_on_n = 1'b1;
        check("R7", phase_o, 0);
        // R8: full low run releases.
        enter_recv();
        data_in = 1'b0;
        repeat (DLM - 1) @(negedge clk);
        check("R8", phase_o, 3);
        @(negedge clk);
        check("R8", phase_o, 0);
        data_in = 1'b1;

        // Constrained random phase.
        dip = 0;
        for (int c = 0; c < 20000; c++) begin
            chk_pass = ($urandom % 12) == 0;
            chk_fail = ($urandom % 20) == 0;
            pol_on_n = !(($urandom % 80) == 0);
            if (dip > 0) begin data_in = 1'b0; dip--; end
            else begin
                data_in = 1'b1;
                if (($urandom % 30) == 0) dip = 1 + ($urandom % (DLM + 2));
            end
            if (($urandom % 150) == 0) cfg_sleep = 5'($urandom % 32);
            @(negedge clk);
        end
        chk_pass = 1'b0; chk_fail = 1'b0; pol_on_n = 1'b1; data_in = 1'b1;
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule